// File: doc/BRIEF.md
# Short-Cycle Successive-Approximation Sequencer

This block steps a successive-approximation register through a conversion. It works with an external DAC and comparator. A start command is accepted only while the block is idle. When it is accepted, the register is cleared and the internal stepping is enabled.

The block then trials one bit at a time, from the most significant bit down. Each trial takes two clocks. In the first clock the trial bit is driven to the DAC. In the second clock the comparator answer is sampled and the bit is either kept or dropped.

A length select, captured with the start, picks between two lengths:

- a full conversion over all bits;
- a short conversion that stops after the upper bits and leaves the low bits at zero.

A busy status covers the whole conversion. Two end-of-conversion flags drop at the start. The short-point flag returns high after the eighth trial. The full-point flag returns high at completion. A one-clock done pulse marks the end.

Once a conversion is running it cannot be aborted or restarted. Further starts are ignored until it ends.

Top module: `sar_shortcycle_ctrl`

## Requirements
- R1: After reset, busy_o is 0, done_o is 0, eoc_short_o and eoc_full_o are both 1, and sar_o is all zeros.
- R2: A start_i high at a clock edge while busy_o is 0 is accepted. After that edge, busy_o is 1, both eoc flags are 0 and sar_o is all zeros.
- R3: One clock after acceptance, sar_o holds only the most significant bit (bit NBITS-1). Each later trial bit is applied one clock before its comparator sample, so every bit takes two clocks, in order from the top bit down.
- R4: At the sample clock of a trial, the trial bit stays 1 if cmp_i is 1 (DAC sum below the input) and is cleared if cmp_i is 0. Bits already decided are not changed.
- R5: With short_i = 0 at acceptance, busy_o stays high for exactly 2*NBITS clocks (24 by default) after the accepting edge.
- R6: With short_i = 1 at acceptance, busy_o stays high for exactly 2*SHORT_BITS clocks (16 by default). The lowest NBITS-SHORT_BITS bits of the result are 0.
- R7: eoc_short_o returns high at the sample edge of the eighth trial (clock 16) in both modes. eoc_full_o returns high when busy_o falls. eoc_full_o is never high while eoc_short_o is low.
- R8: start_i while busy_o is 1 is ignored. short_i is used only at an accepted start.
- R9: done_o is high for exactly one clock, in the clock in which busy_o has just fallen.
- R10: While idle and without a start, sar_o holds the last result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start request |
| short_i | input | 1 | 1 selects the short conversion at start |
| cmp_i | input | 1 | Comparator: 1 when the DAC sum is below the input |
| sar_o | output | NBITS | Register value: trial code to the DAC, result when idle |
| busy_o | output | 1 | Conversion status |
| eoc_short_o | output | 1 | Short-point end-of-conversion flag |
| eoc_full_o | output | 1 | Full-point end-of-conversion flag |
| done_o | output | 1 | One-clock completion pulse |

## Verification
A stuck or skipped bit index shows in two places. The first is sar_o one clock after the start, which must hold only the top bit. The second is the final code, which differs from the analog value the comparator was modelling within one conversion.

A wrong length latch or wrong last-index logic moves the busy fall away from clock 16 or 24, so it shows at the first completion. A restart that is wrongly accepted shows the same way, along with a corrupted result.

Flag misordering shows as eoc_short_o rising at a clock other than 16. A flag state machine that mishandles the end shows as a done pulse that does not line up with the busy fall.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_APPLY  = 2'd1,
      ST_SAMPLE = 2'd2
   } sar_state_e;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_pkg::*;
#(
   parameter int NBITS      = 12,
   parameter int SHORT_BITS = 8,
   parameter bit SHORT_EN   = 1'b1,
   localparam int IW        = (NBITS > 1) ? $clog2(NBITS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          short_i,
   output logic          busy_o,
   output logic          clear_o,
   output logic          apply_o,
   output logic          sample_o,
   output logic          finish_o,
   output logic          short_mark_o,
   output logic [IW-1:0] idx_o
);
   localparam logic [IW-1:0] TOP_IDX   = IW'(NBITS - 1);
   localparam logic [IW-1:0] SHORT_IDX = IW'(NBITS - SHORT_BITS);

   sar_state_e    state_q;
   logic [IW-1:0] idx_q;
   logic          short_q;
   logic [IW-1:0] last_idx;
   logic          short_sel;

   generate
      if (SHORT_EN) begin : g_short
         assign short_sel = short_i;
         assign last_idx  = short_q ? SHORT_IDX : '0;
      end else begin : g_full_only
         assign short_sel = 1'b0;
         assign last_idx  = '0;
      end
   endgenerate

   assign clear_o      = (state_q == ST_IDLE) && start_i;
   assign apply_o      = (state_q == ST_APPLY);
   assign sample_o     = (state_q == ST_SAMPLE);
   assign finish_o     = sample_o && (idx_q == last_idx);
   assign short_mark_o = sample_o && (idx_q == SHORT_IDX);
   assign busy_o       = (state_q != ST_IDLE);
   assign idx_o        = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         short_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_APPLY;
                  idx_q   <= TOP_IDX;
                  short_q <= short_sel;
               end
            end
            ST_APPLY: state_q <= ST_SAMPLE;
            ST_SAMPLE: begin
               if (finish_o) begin
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_APPLY;
                  idx_q   <= idx_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
   parameter int NBITS = 12,
   localparam int IW   = (NBITS > 1) ? $clog2(NBITS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             apply_i,
   input  logic             sample_i,
   input  logic             cmp_i,
   input  logic [IW-1:0]    idx_i,
   output logic [NBITS-1:0] sar_o
);
   generate
      for (genvar b = 0; b < NBITS; b++) begin : g_bit
         logic sel;
         assign sel = (idx_i == IW'(b));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sar_o[b] <= 1'b0;
            end else if (clear_i) begin
               sar_o[b] <= 1'b0;
            end else if (apply_i && sel) begin
               sar_o[b] <= 1'b1;
            end else if (sample_i && sel && !cmp_i) begin
               sar_o[b] <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sar_eoc_flags.sv
module sar_eoc_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic short_mark_i,
   input  logic finish_i,
   output logic eoc_short_o,
   output logic eoc_full_o,
   output logic done_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_short_o <= 1'b1;
         eoc_full_o  <= 1'b1;
         done_o      <= 1'b0;
      end else begin
         done_o <= finish_i;
         if (clear_i) begin
            eoc_short_o <= 1'b0;
            eoc_full_o  <= 1'b0;
         end else begin
            if (short_mark_i || finish_i) eoc_short_o <= 1'b1;
            if (finish_i)                 eoc_full_o  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sar_shortcycle_ctrl.sv
module sar_shortcycle_ctrl #(
   parameter int NBITS      = 12,
   parameter int SHORT_BITS = 8,
   parameter bit SHORT_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             short_i,
   input  logic             cmp_i,
   output logic [NBITS-1:0] sar_o,
   output logic             busy_o,
   output logic             eoc_short_o,
   output logic             eoc_full_o,
   output logic             done_o
);
   localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;

   generate
      if (NBITS < 2)                               $error("NBITS must be at least 2");
      if (SHORT_BITS < 1 || SHORT_BITS >= NBITS)   $error("SHORT_BITS must lie in 1..NBITS-1");
   endgenerate

   logic          clear_w, apply_w, sample_w, finish_w, mark_w;
   logic [IW-1:0] idx_w;

   sar_seq_ctrl #(
      .NBITS(NBITS), .SHORT_BITS(SHORT_BITS), .SHORT_EN(SHORT_EN)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_i(short_i),
      .busy_o(busy_o), .clear_o(clear_w), .apply_o(apply_w),
      .sample_o(sample_w), .finish_o(finish_w), .short_mark_o(mark_w),
      .idx_o(idx_w)
   );

   sar_bit_reg #(.NBITS(NBITS)) u_reg (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_w), .apply_i(apply_w),
      .sample_i(sample_w), .cmp_i(cmp_i), .idx_i(idx_w), .sar_o(sar_o)
   );

   sar_eoc_flags u_flags (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_w), .short_mark_i(mark_w),
      .finish_i(finish_w), .eoc_short_o(eoc_short_o),
      .eoc_full_o(eoc_full_o), .done_o(done_o)
   );
endmodule

// File: rtl/sar_shortcycle_ctrl_chk.sv
module sar_shortcycle_ctrl_chk #(
   parameter int NBITS      = 12,
   parameter int SHORT_BITS = 8,
   parameter bit SHORT_EN   = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             short_i,
   input logic [NBITS-1:0] sar_o,
   input logic             busy_o,
   input logic             eoc_short_o,
   input logic             eoc_full_o,
   input logic             done_o
);
   localparam logic [NBITS-1:0] TOP_ONLY = {1'b1, {(NBITS-1){1'b0}}};

   int   cnt_q;
   logic short_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= 0;
         short_q <= 1'b0;
      end else if (!busy_o && start_i) begin
         cnt_q   <= 0;
         short_q <= short_i && SHORT_EN;
      end else if (busy_o) begin
         cnt_q <= cnt_q + 1;
      end
   end

   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && !eoc_short_o && !eoc_full_o && sar_o == '0));

   a_r3_top_bit_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> ##1 (sar_o == TOP_ONLY));

   a_r5_r6_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (cnt_q == (short_q ? 2*SHORT_BITS : 2*NBITS)));

   a_r7_flag_order: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_full_o |-> eoc_short_o);

   a_r7_full_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !eoc_full_o);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r9_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(sar_o));
endmodule

bind sar_shortcycle_ctrl sar_shortcycle_ctrl_chk #(
   .NBITS(NBITS), .SHORT_BITS(SHORT_BITS), .SHORT_EN(SHORT_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_i(short_i),
   .sar_o(sar_o), .busy_o(busy_o), .eoc_short_o(eoc_short_o),
   .eoc_full_o(eoc_full_o), .done_o(done_o)
);

// File: tb/sar_shortcycle_ctrl_test.sv
module sar_shortcycle_ctrl_test;
   localparam int N = 12;
   localparam int S = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         short_sel = 1'b0;
   logic         cmp;
   logic [N-1:0] vin = '0;
   logic [N-1:0] sar;
   logic         busy, eoc_s, eoc_f, done;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   // comparator model: DAC sum (trial code) not above the input keeps the bit
   assign cmp = (sar <= vin);

   sar_shortcycle_ctrl uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .short_i(short_sel),
      .cmp_i(cmp), .sar_o(sar), .busy_o(busy), .eoc_short_o(eoc_s),
      .eoc_full_o(eoc_f), .done_o(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_code(input logic [N-1:0] v, input bit sh);
      logic [N-1:0] m;
      m = sh ? ({N{1'b1}} << (N - S)) : {N{1'b1}};
      return v & m;
   endfunction

   task automatic run_conv(input logic [N-1:0] v, input bit sh, input bit poke);
      int fall = -1, done_at = -1, eocs_at = -1, dones = 0;
      logic [N-1:0] held;
      vin = v;
      @(negedge clk); start = 1'b1; short_sel = sh;
      @(negedge clk); start = 1'b0; short_sel = ~sh;
      check(busy && !eoc_s && !eoc_f && sar == '0, "R2 start clears",
            {busy, eoc_s, eoc_f, (sar == '0)}, 4'b1001);
      for (int n = 1; n <= 40; n++) begin
         @(negedge clk);
         if (n == 1) check(sar == (1 << (N-1)), "R3 top bit first", sar, 1 << (N-1));
         if (poke && n == 5) begin start = 1'b1; short_sel = 1'b1; end
         if (poke && n == 6) begin start = 1'b0; short_sel = 1'b0; end
         if (done) begin dones++; if (done_at < 0) done_at = n; end
         if (eoc_s && eocs_at < 0) eocs_at = n;
         if (!busy && fall < 0) fall = n;
         if (fall > 0 && n > fall + 1) break;
      end
      check(fall == (sh ? 2*S : 2*N), sh ? "R6 short length" : "R5 full length",
            fall, sh ? 2*S : 2*N);
      check(done_at == fall && dones == 1, "R9 done pulse", done_at * 10 + dones, fall * 10 + 1);
      check(eocs_at == 2*S, "R7 short flag time", eocs_at, 2*S);
      check(eoc_f == 1'b1, "R7 full flag at end", eoc_f, 1);
      check(sar == exp_code(v, sh), sh ? "R6 short result" : "R4 result", sar, exp_code(v, sh));
      if (poke) check(sar == exp_code(v, sh), "R8 restart ignored", sar, exp_code(v, sh));
      held = sar;
      vin = ~v;
      repeat (3) @(negedge clk);
      check(sar == held && !busy, "R10 idle hold", sar, held);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      check(!busy && !done && eoc_s && eoc_f && sar == '0, "R1 reset state",
            {busy, done, eoc_s, eoc_f}, 4'b0011);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 directed corners
      run_conv(12'hFFF, 1'b0, 1'b0);
      run_conv(12'h000, 1'b0, 1'b0);
      run_conv(12'hA5C, 1'b0, 1'b0);
      // R6 short corners
      run_conv(12'hFFF, 1'b1, 1'b0);
      run_conv(12'h80F, 1'b1, 1'b0);
      // R8 restart during conversion
      run_conv(12'h3C7, 1'b0, 1'b1);
      run_conv(12'h6E9, 1'b1, 1'b1);
      for (int i = 0; i < 30; i++) begin
         run_conv(N'($urandom), 1'($urandom), 1'($urandom));
      end
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule